// File: doc/BRIEF.md
# Dual-Bank Gamut Remap Matrix

This block transforms RGB pixels with a 3x4 colour matrix: each output channel is a weighted sum of the three input channels plus a constant offset. Two complete sets of twelve 16-bit coefficients are held in registers. A 2-bit mode selects bypass, the first set (bank A) or the second set (bank B). Each set occupies six 32-bit registers, two coefficients per register.

Software writes a requested mode at any time. The mode that is actually applied (the active mode) is copied from the requested mode only on a frame-start pulse, so the bank in use never changes in the middle of a frame. The active mode can be read back. Software reads it, loads the bank that is not in use, requests that bank, and the swap happens at the next frame boundary.

The datapath has three pipeline stages. It multiplies in signed fixed point, accumulates at full precision, rounds to nearest and clamps to the pixel range. Bypassed pixels go through the same three stages, so their timing matches transformed pixels.

Top module: `dual_bank_gamut_remap`

## Requirements
- R1: After reset the requested mode, the active mode, every coefficient register and `out_valid` are all zero.
- R2: Register map. Address 0 is control. Writing it sets the requested mode from bits [1:0]. Reading it returns the requested mode in bits [1:0] and the active mode in bits [5:4]. Bank A sits at addresses 8..13 and bank B at 16..21. Bank register k holds coefficient 2k in bits [15:0] and coefficient 2k+1 in bits [31:16]. The coefficient order is C11 C12 C13 C14 C21 C22 C23 C24 C31 C32 C33 C34, where row 1 gives red, row 2 green, row 3 blue, and columns 1..3 multiply red, green, blue. A written bank register reads back unchanged.
- R3: Mode encoding: 0 is bypass, 1 is bank A, 2 is bank B, 3 is bypass.
- R4: The active mode takes the requested mode only in a cycle where `frame_start` is high. Writing control between pulses does not change the mode applied to pixels.
- R5: With a bank selected, output channel i = clamp(round((Ci1*R + Ci2*G + Ci3*B + Ci4*8192) / 8192)). The coefficients Ci1..Ci3 are signed two's complement Q2.13, and Ci4 is a signed offset in pixel units.
- R6: Rounding is to nearest, with exact halves rounded toward positive infinity (for example 3.5 becomes 4 and -1.5 becomes -1).
- R7: Results below 0 give 0, and results above 2^PIX_W-1 give 2^PIX_W-1.
- R8: `out_valid` and the output pixel appear exactly 3 cycles after the input is sampled, in every mode. In bypass the output equals the input.
- R9: A pixel uses the active mode of the cycle in which it is presented. A pixel presented together with `frame_start` still uses the old mode.
- R10: Writes to addresses outside control and the two banks change nothing, and reads of such addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Register address for write and read |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational from `cfg_addr`) |
| frame_start | input | 1 | Frame-boundary pulse; copies the requested mode into the active mode |
| in_valid | input | 1 | Input pixel valid |
| in_r | input | PIX_W | Input red |
| in_g | input | PIX_W | Input green |
| in_b | input | PIX_W | Input blue |
| out_valid | output | 1 | Output pixel valid |
| out_r | output | PIX_W | Output red |
| out_g | output | PIX_W | Output green |
| out_b | output | PIX_W | Output blue |

## Verification
Each mode is driven with a grid of channel values that mixes the range ends (0, 1, 1023) with points just around mid-scale. A wrong channel order, a swapped row, a sign error or a wrong offset scale then shows up as a distinct wrong value in a distinct channel.

One bank holds mixed-sign coefficients with large and negative offsets, so the grid drives results past both clamp limits. The other bank holds half-weight terms, and chosen pixels land exactly on .5 results, which separates round-half-up from truncation and from round-half-even.

A mode write followed later by a frame pulse that coincides with a pixel shows whether the swap is deferred and where the boundary falls. Writes to unmapped addresses followed by readback and a further sweep show whether stray writes leak into a bank.

// File: rtl/cm_pkg.sv
`timescale 1ns/1ps
package cm_pkg;
  localparam int CF_W  = 16;          // coefficient width
  localparam int FRAC  = 13;          // fraction bits of multipliers
  localparam int NCOEF = 12;          // 3 rows x 4 columns
  localparam int REG_W = 2 * CF_W;    // two coefficients per register
  localparam int NREG  = NCOEF / 2;   // registers per bank

  typedef enum logic [1:0] {
    MODE_BYPASS = 2'd0,
    MODE_BANK_A = 2'd1,
    MODE_BANK_B = 2'd2,
    MODE_RSVD   = 2'd3
  } cm_mode_e;
endpackage

// File: rtl/cm_coef_bank.sv
`timescale 1ns/1ps
module cm_coef_bank
  import cm_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int BASE   = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [REG_W-1:0]            wdata,
  output logic                        rd_hit,
  output logic [REG_W-1:0]            rd_data,
  output logic [NCOEF-1:0][CF_W-1:0]  coef_o
);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);

  logic [ADDR_W-1:0] offs;
  logic [REG_W-1:0]  regs [NREG];

  assign offs   = addr - BASE_A;
  assign rd_hit = (addr >= BASE_A) && (offs < ADDR_W'(NREG));

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)
        regs[k] <= '0;
      else if (wr_en && rd_hit && offs == ADDR_W'(k))
        regs[k] <= wdata;
    end
    // low half is the even coefficient, high half the odd one
    assign coef_o[2*k]   = regs[k][CF_W-1:0];
    assign coef_o[2*k+1] = regs[k][REG_W-1:CF_W];
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NREG; k++)
      if (rd_hit && offs == ADDR_W'(k)) rd_data = regs[k];
  end
endmodule

// File: rtl/cm_mode_latch.sv
`timescale 1ns/1ps
module cm_mode_latch
  import cm_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     ctrl_we,
  input  logic [1:0] ctrl_mode,
  input  logic     frame_start,
  output cm_mode_e req_mode,
  output cm_mode_e act_mode
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_mode <= MODE_BYPASS;
      act_mode <= MODE_BYPASS;
    end else begin
      if (ctrl_we)     req_mode <= cm_mode_e'(ctrl_mode);
      if (frame_start) act_mode <= req_mode;
    end
  end
endmodule

// File: rtl/cm_datapath.sv
`timescale 1ns/1ps
module cm_datapath
  import cm_pkg::*;
#(
  parameter int PIX_W = 10
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic [2:0][PIX_W-1:0]       in_pix,
  input  cm_mode_e                    mode,
  input  logic [NCOEF-1:0][CF_W-1:0]  coef_a,
  input  logic [NCOEF-1:0][CF_W-1:0]  coef_b,
  output logic                        out_valid,
  output logic [2:0][PIX_W-1:0]       out_pix
);
  localparam int PROD_W = PIX_W + 1 + CF_W;
  localparam int WIDE_W = (PROD_W > CF_W + FRAC) ? PROD_W : CF_W + FRAC;
  localparam int ACC_W  = WIDE_W + 3;
  localparam logic signed [ACC_W-1:0] HALF    = ACC_W'(1) << (FRAC - 1);
  localparam logic signed [ACC_W-1:0] PIX_MAX = ACC_W'((1 << PIX_W) - 1);

  function automatic logic signed [PROD_W-1:0] mul_term(
    input logic [PIX_W-1:0] p, input logic [CF_W-1:0] c);
    logic signed [PROD_W-1:0] a, b;
    a = PROD_W'($signed({1'b0, p}));
    b = PROD_W'($signed(c));
    return a * b;
  endfunction

  function automatic logic [PIX_W-1:0] round_sat(input logic signed [ACC_W-1:0] acc);
    logic signed [ACC_W-1:0] rnd;
    rnd = (acc + HALF) >>> FRAC;
    if (rnd < 0)            return '0;
    else if (rnd > PIX_MAX) return PIX_MAX[PIX_W-1:0];
    else                    return rnd[PIX_W-1:0];
  endfunction

  // stage 1: sample pixel together with the mode active now
  logic                  s1_valid;
  logic [2:0][PIX_W-1:0] s1_pix;
  cm_mode_e              s1_mode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_pix   <= '0;
      s1_mode  <= MODE_BYPASS;
    end else begin
      s1_valid <= in_valid;
      s1_pix   <= in_pix;
      s1_mode  <= mode;
    end
  end

  logic [NCOEF-1:0][CF_W-1:0] cf_sel;
  logic                       s1_bypass;
  assign cf_sel    = (s1_mode == MODE_BANK_B) ? coef_b : coef_a;
  assign s1_bypass = !(s1_mode == MODE_BANK_A || s1_mode == MODE_BANK_B);

  // stage 2: nine products and three offsets
  logic                     s2_valid, s2_bypass;
  logic [2:0][PIX_W-1:0]    s2_pix;
  logic signed [PROD_W-1:0] s2_prod [3][3];
  logic [CF_W-1:0]          s2_off  [3];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s2_valid  <= 1'b0;
      s2_bypass <= 1'b1;
      s2_pix    <= '0;
      for (int i = 0; i < 3; i++) begin
        s2_off[i] <= '0;
        for (int j = 0; j < 3; j++) s2_prod[i][j] <= '0;
      end
    end else begin
      s2_valid  <= s1_valid;
      s2_bypass <= s1_bypass;
      s2_pix    <= s1_pix;
      for (int i = 0; i < 3; i++) begin
        s2_off[i] <= cf_sel[4*i+3];
        for (int j = 0; j < 3; j++)
          s2_prod[i][j] <= mul_term(s1_pix[j], cf_sel[4*i+j]);
      end
    end
  end

  // stage 3: accumulate, round, clamp
  logic signed [ACC_W-1:0] acc [3];
  always_comb begin
    for (int i = 0; i < 3; i++)
      acc[i] = ACC_W'(s2_prod[i][0]) + ACC_W'(s2_prod[i][1]) + ACC_W'(s2_prod[i][2])
             + (ACC_W'($signed(s2_off[i])) <<< FRAC);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
    end else begin
      out_valid <= s2_valid;
      for (int i = 0; i < 3; i++)
        out_pix[i] <= s2_bypass ? s2_pix[i] : round_sat(acc[i]);
    end
  end
endmodule

// File: rtl/dual_bank_gamut_remap.sv
`timescale 1ns/1ps
module dual_bank_gamut_remap
  import cm_pkg::*;
#(
  parameter int PIX_W       = 10,
  parameter int ADDR_W      = 5,
  parameter int BANK_A_BASE = 8,
  parameter int BANK_B_BASE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              frame_start,
  input  logic              in_valid,
  input  logic [PIX_W-1:0]  in_r,
  input  logic [PIX_W-1:0]  in_g,
  input  logic [PIX_W-1:0]  in_b,
  output logic              out_valid,
  output logic [PIX_W-1:0]  out_r,
  output logic [PIX_W-1:0]  out_g,
  output logic [PIX_W-1:0]  out_b
);
  localparam int NBANK = 2;

  // named internal events used by the checker
  logic     ctrl_we;
  cm_mode_e req_mode, act_mode;

  assign ctrl_we = cfg_we && (cfg_addr == '0);

  cm_mode_latch u_mode (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_mode(cfg_wdata[1:0]),
    .frame_start(frame_start), .req_mode(req_mode), .act_mode(act_mode)
  );

  logic [NCOEF-1:0][CF_W-1:0] coefs [NBANK];
  logic [REG_W-1:0]           bank_rd [NBANK];
  logic [NBANK-1:0]           bank_hit;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    cm_coef_bank #(
      .ADDR_W(ADDR_W),
      .BASE  ((b == 0) ? BANK_A_BASE : BANK_B_BASE)
    ) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
      .rd_hit(bank_hit[b]), .rd_data(bank_rd[b]), .coef_o(coefs[b])
    );
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr == '0)
      cfg_rdata = {26'd0, logic'(act_mode[1]), logic'(act_mode[0]), 2'b00, req_mode};
    for (int b = 0; b < NBANK; b++)
      if (bank_hit[b]) cfg_rdata = bank_rd[b];
  end

  logic [2:0][PIX_W-1:0] pix_out;

  cm_datapath #(.PIX_W(PIX_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pix({in_b, in_g, in_r}),
    .mode(act_mode), .coef_a(coefs[0]), .coef_b(coefs[1]),
    .out_valid(out_valid), .out_pix(pix_out)
  );

  assign out_r = pix_out[0];
  assign out_g = pix_out[1];
  assign out_b = pix_out[2];
endmodule

// File: rtl/cm_remap_checks.sv
`timescale 1ns/1ps
module cm_remap_checks #(
  parameter int PIX_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_start,
  input logic             ctrl_we,
  input logic [1:0]       ctrl_wmode,
  input logic [1:0]       req_mode,
  input logic [1:0]       act_mode,
  input logic             in_valid,
  input logic [PIX_W-1:0] in_r,
  input logic [PIX_W-1:0] in_g,
  input logic [PIX_W-1:0] in_b,
  input logic             out_valid,
  input logic [PIX_W-1:0] out_r,
  input logic [PIX_W-1:0] out_g,
  input logic [PIX_W-1:0] out_b
);
  // edges seen since reset, saturating, so 3-deep history is only used once valid
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (!rst_n)         age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  logic byp_in;
  assign byp_in = (act_mode != 2'd1) && (act_mode != 2'd2);

  a_r2_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> req_mode == $past(ctrl_wmode));

  a_r4_swap_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> act_mode == $past(req_mode));

  a_r4_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(act_mode));

  a_r8_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3) |-> out_valid == $past(in_valid, 3));

  a_r8_bypass_data: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && out_valid && $past(byp_in, 3)) |->
      (out_r == $past(in_r, 3) && out_g == $past(in_g, 3) && out_b == $past(in_b, 3)));
endmodule

bind dual_bank_gamut_remap cm_remap_checks #(.PIX_W(PIX_W)) u_checks (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .ctrl_we(ctrl_we),
  .ctrl_wmode(cfg_wdata[1:0]), .req_mode(req_mode), .act_mode(act_mode),
  .in_valid(in_valid), .in_r(in_r), .in_g(in_g), .in_b(in_b),
  .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b)
);

// File: tb/test_dual_bank_gamut_remap.sv
`timescale 1ns/1ps
module test_dual_bank_gamut_remap;
  localparam int PIX_W = 10;
  localparam int ADDR_W = 5;
  localparam int ABASE = 8;
  localparam int BBASE = 16;
  localparam int PMAX = (1 << PIX_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [ADDR_W-1:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic frame_start = 1'b0;
  logic in_valid = 1'b0;
  logic [PIX_W-1:0] in_r = '0, in_g = '0, in_b = '0;
  logic out_valid;
  logic [PIX_W-1:0] out_r, out_g, out_b;

  always #10 clk = ~clk;   // 50 MHz

  dual_bank_gamut_remap #(.PIX_W(PIX_W), .ADDR_W(ADDR_W),
                          .BANK_A_BASE(ABASE), .BANK_B_BASE(BBASE)) i_dual_bank_gamut_remap (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .frame_start(frame_start), .in_valid(in_valid),
    .in_r(in_r), .in_g(in_g), .in_b(in_b), .out_valid(out_valid),
    .out_r(out_r), .out_g(out_g), .out_b(out_b)
  );

  int nchk = 0, nerr = 0, cyc = 0;
  bit done = 1'b0;
  int ca [12], cb [12];
  int breq = 0, bact = 0;   // bench's own view of requested/active mode

  typedef struct { int r; int g; int b; int stamp; string tag; } exp_t;
  exp_t q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int ch_model(int c0, int c1, int c2, int off, int r, int g, int b);
    longint s;
    s = longint'(c0) * r + longint'(c1) * g + longint'(c2) * b + longint'(off) * 8192 + 4096;
    s = s >>> 13;
    if (s < 0) return 0;
    if (s > PMAX) return PMAX;
    return int'(s);
  endfunction

  function automatic logic [31:0] pack(input int c [12], input int k);
    return {16'(c[2*k+1]), 16'(c[2*k])};
  endfunction

  task automatic reg_write(input int addr, input logic [31:0] d);
    @(negedge clk);
    in_valid = 1'b0; frame_start = 1'b0;
    cfg_we = 1'b1; cfg_addr = ADDR_W'(addr); cfg_wdata = d;
    if (addr == 0) breq = int'(d[1:0]);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_chk(input int addr, input logic [31:0] exp, input string tag);
    @(negedge clk);
    cfg_we = 1'b0; in_valid = 1'b0; frame_start = 1'b0; cfg_addr = ADDR_W'(addr);
    #1;
    chk(cfg_rdata == exp, tag, cfg_rdata, exp);
  endtask

  task automatic send(input int r, input int g, input int b, input bit fs, input string tag);
    exp_t e;
    @(negedge clk);
    cfg_we = 1'b0;
    in_valid = 1'b1; frame_start = fs;
    in_r = PIX_W'(r); in_g = PIX_W'(g); in_b = PIX_W'(b);
    e.r = r; e.g = g; e.b = b; e.stamp = cyc; e.tag = tag;
    if (bact == 1) begin
      e.r = ch_model(ca[0], ca[1], ca[2], ca[3], r, g, b);
      e.g = ch_model(ca[4], ca[5], ca[6], ca[7], r, g, b);
      e.b = ch_model(ca[8], ca[9], ca[10], ca[11], r, g, b);
    end else if (bact == 2) begin
      e.r = ch_model(cb[0], cb[1], cb[2], cb[3], r, g, b);
      e.g = ch_model(cb[4], cb[5], cb[6], cb[7], r, g, b);
      e.b = ch_model(cb[8], cb[9], cb[10], cb[11], r, g, b);
    end
    q.push_back(e);
    if (fs) bact = breq;   // pixel above used the old mode (R9)
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; frame_start = 1'b0;
    end
  endtask

  task automatic frame_pulse();
    @(negedge clk);
    in_valid = 1'b0; frame_start = 1'b1;
    bact = breq;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  task automatic sweep(input string tag);
    int vals [8] = '{0, 1, 3, 100, 511, 512, 1000, 1023};
    foreach (vals[i]) foreach (vals[j]) foreach (vals[k])
      send(vals[i], vals[j], vals[k], 1'b0, tag);
    idle(1);
  endtask

  // output checker: compares each valid output with the oldest expectation
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_valid) begin
        if (q.size() == 0) chk(1'b0, "R8 unexpected out_valid", 1, 0);
        else begin
          exp_t e;
          e = q.pop_front();
          chk(cyc - e.stamp == 3, {"R8 latency ", e.tag}, cyc - e.stamp, 3);
          chk(int'(out_r) == e.r, {e.tag, " red"},   out_r, e.r);
          chk(int'(out_g) == e.g, {e.tag, " green"}, out_g, e.g);
          chk(int'(out_b) == e.b, {e.tag, " blue"},  out_b, e.b);
        end
      end else if (q.size() > 0 && cyc - q[0].stamp > 3) begin
        chk(1'b0, {"R8 missing output ", q[0].tag}, 0, 1);
        void'(q.pop_front());
      end
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1'b1;
      nchk++; nerr++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    // bank A: mixed signs, big offsets -> both clamp ends
    ca = '{8192, 4096, -2048, 3,   -4096, 16384, 1024, -40,   1000, -3000, 12000, 500};
    // bank B: half weights -> exact .5 results
    cb = '{4096, 4096, 0, 0,       0, -8192, 0, 1023,         0, 0, -4096, 5};

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    rd_chk(0, 32'd0, "R1 control after reset");
    for (int k = 0; k < 6; k++) begin
      rd_chk(ABASE + k, 32'd0, "R1 bank A after reset");
      rd_chk(BBASE + k, 32'd0, "R1 bank B after reset");
    end

    // R2: load and read back both banks
    for (int k = 0; k < 6; k++) begin
      reg_write(ABASE + k, pack(ca, k));
      reg_write(BBASE + k, pack(cb, k));
    end
    for (int k = 0; k < 6; k++) begin
      rd_chk(ABASE + k, pack(ca, k), "R2 bank A readback");
      rd_chk(BBASE + k, pack(cb, k), "R2 bank B readback");
    end

    // R10: stray writes change nothing
    reg_write(14, 32'hFFFF_FFFF);
    reg_write(5, 32'hFFFF_FFFF);
    reg_write(31, 32'hFFFF_FFFF);
    reg_write(22, 32'hFFFF_FFFF);
    rd_chk(14, 32'd0, "R10 unmapped read");
    rd_chk(22, 32'd0, "R10 unmapped read");
    rd_chk(0, 32'd0, "R10 control untouched");
    for (int k = 0; k < 6; k++) begin
      rd_chk(ABASE + k, pack(ca, k), "R10 bank A untouched");
      rd_chk(BBASE + k, pack(cb, k), "R10 bank B untouched");
    end

    // R8: bypass after reset passes pixels unchanged with same latency
    sweep("R8 bypass");

    // R4: request bank A, no pulse yet
    reg_write(0, 32'd1);
    rd_chk(0, 32'h0000_0001, "R4 requested set, active still bypass");
    send(100, 200, 300, 1'b0, "R4 before pulse");
    send(7, 8, 9, 1'b0, "R4 before pulse");
    // R9: pixel with the pulse keeps the old mode, next one uses bank A
    send(600, 50, 900, 1'b1, "R9 pixel with pulse");
    send(600, 50, 900, 1'b0, "R9 pixel after pulse");
    idle(4);
    rd_chk(0, 32'h0000_0011, "R2 control readback active A");

    // R5 and R7 on bank A
    sweep("R5 bank A");
    send(1023, 1023, 1023, 1'b0, "R7 clamp high");
    send(1023, 0, 1023, 1'b0, "R7 clamp low");
    send(0, 0, 0, 1'b0, "R5 offset only");

    // R4: request B, stay on A until the pulse
    reg_write(0, 32'd2);
    send(300, 400, 500, 1'b0, "R4 still bank A");
    idle(4);
    rd_chk(0, 32'h0000_0012, "R4 active unchanged before pulse");
    frame_pulse();
    rd_chk(0, 32'h0000_0022, "R4 active after pulse");

    // R5 and R6 on bank B
    sweep("R5 bank B");
    send(3, 3, 3, 1'b0, "R6 half up");
    send(1, 0, 1, 1'b0, "R6 half up");
    send(0, 1, 0, 1'b0, "R6 half up");

    // R3: mode 3 acts as bypass
    reg_write(0, 32'd3);
    frame_pulse();
    rd_chk(0, 32'h0000_0033, "R3 reserved mode readback");
    sweep("R3 mode 3 bypass");

    // R3: back to explicit bypass with mode 0
    reg_write(0, 32'd0);
    frame_pulse();
    send(321, 654, 987, 1'b0, "R3 mode 0 bypass");

    idle(8);
    chk(q.size() == 0, "R8 all outputs delivered", q.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule